// File: doc/BRIEF.md
# Register-Triggered Word Copy Engine

This block is a small copy engine behind a 32-byte register window on a plain CPU slave bus. Software loads a source address, a destination address and an optional byte-reverse option. It then writes a word count to the length register. That write starts the copy. Each 32-bit word is read from the source through a master read port and written to the destination through a master write port. Both addresses step by 4 after each word. When the last word has been written, the length register returns to zero, a completion flag is set in the status byte and the interrupt line rises. Software acknowledges the interrupt by writing a 1 to bit 0 of the control byte.

A command/result register pair answers two kinds of query. A command with bit 29 set loads a fixed identification word into the result register. A command with bit 31 set and bit 29 clear issues one read on a separate side port and stores the returned word as the result.

The master read, master write and side read request channels use valid/ready handshakes. A request stays asserted, with its address and data unchanged, until the cycle in which ready is seen high; the transfer happens in that cycle. A read response is a single-cycle `*_rsp_valid` pulse and has no ready signal. The engine is always able to take the response while it waits for one. The slave must return exactly one response for each accepted request, no earlier than the cycle after acceptance.

Top module: `wdma_engine`

## Requirements
- R1: After reset, every register in the window reads 0, `irq` is low, and no request valid is asserted.
- R2: A word access at offset a uses bits a[4:2] and addresses bytes a..a+3, with byte a on bits 31:24 and byte a+3 on bits 7:0. A byte access reads or writes one byte on bits 7:0.
- R3: A word write of N to offset 0x08 copies N words. For word i, the engine reads the source value + 4i, then writes that data to the destination value + 4i, in increasing i order, with no other write.
- R4: When bit 7 of the config byte (offset 0x0E) is 1 at start, every copied word is byte-reversed. When that bit is 0, the word is copied unchanged.
- R5: On completion, the length word reads 0, bit 0 of the status byte (offset 0x0C) reads 1, and `irq` is high. `irq` always equals that status bit.
- R6: A byte write to offset 0x0D with data bit 0 = 1 clears status bit 0 and `irq`. With data bit 0 = 0 the write leaves both unchanged.
- R7: A length of 0 completes within two cycles with no memory request, and it still sets status bit 0.
- R8: While a copy is in progress, a word write to offset 0x08 is ignored. The length reads back unchanged and no extra words are copied.
- R9: A word write to offset 0x10 with bit 29 set loads the result word (offset 0x14) with 0x178611DB and issues no side request.
- R10: A word write to offset 0x10 with bit 31 set and bit 29 clear issues one side read at address 0x84000000 | command[7:0]. The returned word then appears at offset 0x14.
- R11: A command with bits 31 and 29 both clear leaves the result unchanged. A word write to offset 0x14 makes the result read 0xFFFFFFFF.
- R12: Under back-pressure, each request's valid, address and data stay stable until accepted, and the copied data stays correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| cfg_addr | input | 5 | Byte offset in the window |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data (combinational from cfg_addr, cfg_word) |
| rd_req_valid | output | 1 | Master read request valid |
| rd_req_ready | input | 1 | Master read request accepted |
| rd_req_addr | output | 32 | Master read byte address |
| rd_rsp_valid | input | 1 | Read response pulse |
| rd_rsp_data | input | 32 | Read response data |
| wr_valid | output | 1 | Master write valid |
| wr_ready | input | 1 | Master write accepted |
| wr_addr | output | 32 | Master write byte address |
| wr_data | output | 32 | Master write data |
| side_req_valid | output | 1 | Side read request valid |
| side_req_ready | input | 1 | Side read request accepted |
| side_req_addr | output | 32 | Side read address |
| side_rsp_valid | input | 1 | Side response pulse |
| side_rsp_data | input | 32 | Side response data |
| irq | output | 1 | Completion interrupt, level |

## Verification
The assertions rely on three things about the inputs. Every response pulse follows its own accepted request by at least one cycle. No response arrives unrequested. A word write to the result offset never lands in the same cycle as a side response. The bench's memory and side-port responders produce at most one response per accepted request, after a random delay of zero to two cycles. The bench issues no result-offset write while a side read is outstanding. Ready lines are driven at random to create stalls; the timing of these stall patterns is unconstrained.

// File: rtl/wdma_pkg.sv
package wdma_pkg;
  localparam int WIN_BYTES = 32;
  localparam int OFF_W     = $clog2(WIN_BYTES);
  localparam int SWAP_BIT  = 7;

  typedef logic [OFF_W-1:0] off_t;

  localparam off_t OFF_SRC  = off_t'(8'h00);
  localparam off_t OFF_DST  = off_t'(8'h04);
  localparam off_t OFF_LEN  = off_t'(8'h08);
  localparam off_t OFF_STAT = off_t'(8'h0C);
  localparam off_t OFF_CTRL = off_t'(8'h0D);
  localparam off_t OFF_CFG  = off_t'(8'h0E);
  localparam off_t OFF_CMD  = off_t'(8'h10);
  localparam off_t OFF_RES  = off_t'(8'h14);

  typedef enum logic [2:0] {MV_IDLE, MV_RD, MV_WAIT, MV_WR, MV_DONE} mv_state_e;
  typedef enum logic [1:0] {CQ_IDLE, CQ_REQ, CQ_WAIT} cq_state_e;

  function automatic logic [31:0] swap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/wdma_regs.sv
module wdma_regs
  import wdma_pkg::*;
#(
  parameter logic [31:0] ID_WORD = 32'h1786_11DB
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic        bus_word,
  input  off_t        bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        mv_busy,
  input  logic        mv_done,
  output logic        mv_start,
  output logic [31:0] mv_src,
  output logic [31:0] mv_dst,
  output logic        mv_swap,
  input  logic        cmd_busy,
  output logic        cmd_launch,
  output logic [7:0]  cmd_index,
  input  logic        cmd_ret_valid,
  input  logic [31:0] cmd_ret_data,
  output logic        irq
);
  logic [7:0] rb [WIN_BYTES];
  off_t wbase;
  logic wr_word_len, wr_ok, ctrl_clear, force_ones, id_load, cmd_wr;
  logic [31:0] len_word, res_word;

  assign wbase       = {bus_addr[OFF_W-1:2], 2'b00};
  assign wr_word_len = bus_we && bus_word && (wbase == OFF_LEN);
  assign wr_ok       = bus_we && !(wr_word_len && mv_busy);
  assign mv_start    = wr_word_len && !mv_busy;
  assign ctrl_clear  = bus_we && !bus_word && (bus_addr == OFF_CTRL) && bus_wdata[0];
  assign cmd_wr      = bus_we && bus_word && (wbase == OFF_CMD);
  assign id_load     = cmd_wr && bus_wdata[29];
  assign cmd_launch  = cmd_wr && !bus_wdata[29] && bus_wdata[31] && !cmd_busy;
  assign cmd_index   = bus_wdata[7:0];
  assign force_ones  = bus_we && bus_word && (wbase == OFF_RES);
  assign mv_swap     = rb[OFF_CFG][SWAP_BIT];
  assign irq         = rb[OFF_STAT][0];

  always_comb begin
    mv_src = '0; mv_dst = '0; len_word = '0; res_word = '0;
    for (int k = 0; k < 4; k++) begin
      mv_src[31-8*k -: 8]   = rb[OFF_SRC + off_t'(k)];
      mv_dst[31-8*k -: 8]   = rb[OFF_DST + off_t'(k)];
      len_word[31-8*k -: 8] = rb[OFF_LEN + off_t'(k)];
      res_word[31-8*k -: 8] = rb[OFF_RES + off_t'(k)];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_word) begin
      for (int k = 0; k < 4; k++) bus_rdata[31-8*k -: 8] = rb[wbase + off_t'(k)];
    end else begin
      bus_rdata[7:0] = rb[bus_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN_BYTES; i++) rb[off_t'(i)] <= '0;
    end else begin
      if (wr_ok) begin
        if (bus_word) begin
          for (int k = 0; k < 4; k++) rb[wbase + off_t'(k)] <= bus_wdata[31-8*k -: 8];
        end else begin
          rb[bus_addr] <= bus_wdata[7:0];
        end
      end
      if (ctrl_clear) rb[OFF_STAT][0] <= 1'b0;
      if (force_ones)
        for (int k = 0; k < 4; k++) rb[OFF_RES + off_t'(k)] <= 8'hFF;
      if (id_load)
        for (int k = 0; k < 4; k++) rb[OFF_RES + off_t'(k)] <= ID_WORD[31-8*k -: 8];
      if (cmd_ret_valid)
        for (int k = 0; k < 4; k++) rb[OFF_RES + off_t'(k)] <= cmd_ret_data[31-8*k -: 8];
      if (mv_done) begin
        for (int k = 0; k < 4; k++) rb[OFF_LEN + off_t'(k)] <= 8'h00;
        rb[OFF_STAT][0] <= 1'b1;
      end
    end
  end

  // R5
  done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mv_done |=> (irq && len_word == 32'h0));

  // R6
  ctrl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_clear && !mv_done) |=> !irq);

  // R8
  busy_len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word_len && mv_busy && !mv_done) |=> $stable(len_word));

  // R9
  id_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_load && !cmd_ret_valid) |=> (res_word == ID_WORD));
endmodule

// File: rtl/wdma_mover.sv
module wdma_mover
  import wdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_src,
  input  logic [AW-1:0] start_dst,
  input  logic [LW-1:0] start_len,
  input  logic          start_swap,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  input  logic          rd_rsp_valid,
  input  logic [31:0]   rd_rsp_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  output logic          busy,
  output logic          done
);
  localparam logic [AW-1:0] STEP = AW'(4);
  localparam logic [LW-1:0] ONE  = LW'(1);

  mv_state_e     st;
  logic [AW-1:0] src_q, dst_q;
  logic [LW-1:0] cnt_q;
  logic          swap_q;
  logic [31:0]   data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= MV_IDLE; src_q <= '0; dst_q <= '0; cnt_q <= '0;
      swap_q <= 1'b0; data_q <= '0;
    end else begin
      unique case (st)
        MV_IDLE: if (start) begin
          src_q  <= start_src;
          dst_q  <= start_dst;
          cnt_q  <= start_len;
          swap_q <= start_swap;
          st     <= (start_len == '0) ? MV_DONE : MV_RD;
        end
        MV_RD: if (rd_req_ready) st <= MV_WAIT;
        MV_WAIT: if (rd_rsp_valid) begin
          data_q <= swap_q ? swap32(rd_rsp_data) : rd_rsp_data;
          st     <= MV_WR;
        end
        MV_WR: if (wr_ready) begin
          src_q <= src_q + STEP;
          dst_q <= dst_q + STEP;
          cnt_q <= cnt_q - ONE;
          st    <= (cnt_q == ONE) ? MV_DONE : MV_RD;
        end
        MV_DONE: st <= MV_IDLE;
        default: st <= MV_IDLE;
      endcase
    end
  end

  assign rd_req_valid = (st == MV_RD);
  assign rd_req_addr  = src_q;
  assign wr_valid     = (st == MV_WR);
  assign wr_addr      = dst_q;
  assign wr_data      = data_q;
  assign busy         = (st != MV_IDLE);
  assign done         = (st == MV_DONE);

  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  // R12
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R7
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && start_len == '0) |=> (done && !rd_req_valid));
endmodule

// File: rtl/wdma_cmd.sv
module wdma_cmd
  import wdma_pkg::*;
#(
  parameter logic [31:0] SIDE_BASE = 32'h8400_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch,
  input  logic [7:0]  index,
  output logic        side_req_valid,
  input  logic        side_req_ready,
  output logic [31:0] side_req_addr,
  input  logic        side_rsp_valid,
  input  logic [31:0] side_rsp_data,
  output logic        busy,
  output logic        ret_valid,
  output logic [31:0] ret_data
);
  cq_state_e   st;
  logic [31:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= CQ_IDLE; addr_q <= '0;
    end else begin
      unique case (st)
        CQ_IDLE: if (launch) begin
          addr_q <= SIDE_BASE | {24'h0, index};
          st     <= CQ_REQ;
        end
        CQ_REQ:  if (side_req_ready) st <= CQ_WAIT;
        CQ_WAIT: if (side_rsp_valid) st <= CQ_IDLE;
        default: st <= CQ_IDLE;
      endcase
    end
  end

  assign side_req_valid = (st == CQ_REQ);
  assign side_req_addr  = addr_q;
  assign busy           = (st != CQ_IDLE);
  assign ret_valid      = (st == CQ_WAIT) && side_rsp_valid;
  assign ret_data       = side_rsp_data;

  // R10
  side_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (side_req_valid && !side_req_ready) |=> (side_req_valid && $stable(side_req_addr)));

  // R10
  side_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !busy) |=> (side_req_valid && side_req_addr[31:8] == SIDE_BASE[31:8]));
endmodule

// File: rtl/wdma_engine.sv
module wdma_engine
  import wdma_pkg::*;
#(
  parameter logic [31:0] ID_WORD   = 32'h1786_11DB,
  parameter logic [31:0] SIDE_BASE = 32'h8400_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_word,
  input  logic [4:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        rd_req_valid,
  input  logic        rd_req_ready,
  output logic [31:0] rd_req_addr,
  input  logic        rd_rsp_valid,
  input  logic [31:0] rd_rsp_data,
  output logic        wr_valid,
  input  logic        wr_ready,
  output logic [31:0] wr_addr,
  output logic [31:0] wr_data,
  output logic        side_req_valid,
  input  logic        side_req_ready,
  output logic [31:0] side_req_addr,
  input  logic        side_rsp_valid,
  input  logic [31:0] side_rsp_data,
  output logic        irq
);
  logic        mv_busy, mv_done, mv_start, mv_swap;
  logic [31:0] mv_src, mv_dst;
  logic        cmd_busy, cmd_launch, cmd_ret_valid;
  logic [7:0]  cmd_index;
  logic [31:0] cmd_ret_data;

  wdma_regs #(.ID_WORD(ID_WORD)) regs_i (
    .clk, .rst_n,
    .bus_we(cfg_we), .bus_word(cfg_word), .bus_addr(cfg_addr),
    .bus_wdata(cfg_wdata), .bus_rdata(cfg_rdata),
    .mv_busy, .mv_done, .mv_start, .mv_src, .mv_dst, .mv_swap,
    .cmd_busy, .cmd_launch, .cmd_index, .cmd_ret_valid, .cmd_ret_data,
    .irq
  );

  wdma_mover #(.AW(32), .LW(32)) mover_i (
    .clk, .rst_n,
    .start(mv_start), .start_src(mv_src), .start_dst(mv_dst),
    .start_len(cfg_wdata), .start_swap(mv_swap),
    .rd_req_valid, .rd_req_ready, .rd_req_addr, .rd_rsp_valid, .rd_rsp_data,
    .wr_valid, .wr_ready, .wr_addr, .wr_data,
    .busy(mv_busy), .done(mv_done)
  );

  wdma_cmd #(.SIDE_BASE(SIDE_BASE)) cmd_i (
    .clk, .rst_n,
    .launch(cmd_launch), .index(cmd_index),
    .side_req_valid, .side_req_ready, .side_req_addr,
    .side_rsp_valid, .side_rsp_data,
    .busy(cmd_busy), .ret_valid(cmd_ret_valid), .ret_data(cmd_ret_data)
  );
endmodule

// File: tb/wdma_engine_tb_top.sv
module wdma_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_word = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        rd_req_valid, rd_req_ready = 1'b0;
  logic [31:0] rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [31:0] rd_rsp_data = '0;
  logic        wr_valid, wr_ready = 1'b0;
  logic [31:0] wr_addr, wr_data;
  logic        side_req_valid, side_req_ready = 1'b0;
  logic [31:0] side_req_addr;
  logic        side_rsp_valid = 1'b0;
  logic [31:0] side_rsp_data = '0;
  logic        irq;

  int n_checks = 0, n_fails = 0;
  bit done_flag = 0;
  bit stall_en = 0;
  logic [31:0] mem [256];
  logic [31:0] snap [256];
  int wr_count = 0, rd_count = 0, side_count = 0;
  logic [31:0] last_side_addr = '0;

  always #10 clk = ~clk;

  wdma_engine dut_i (
    .clk, .rst_n, .cfg_we, .cfg_word, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .rd_req_valid, .rd_req_ready, .rd_req_addr, .rd_rsp_valid, .rd_rsp_data,
    .wr_valid, .wr_ready, .wr_addr, .wr_data,
    .side_req_valid, .side_req_ready, .side_req_addr, .side_rsp_valid, .side_rsp_data,
    .irq
  );

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [31:0] side_val(input logic [31:0] a);
    return {a[7:0], 8'h3C, ~a[7:0], 8'hC3};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input bit word, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_word = word; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, input bit word, output logic [31:0] d);
    cfg_addr = a; cfg_word = word;
    #1 d = cfg_rdata;
  endtask

  task automatic wait_irq(input int limit);
    for (int i = 0; i < limit; i++) begin
      if (irq) break;
      @(negedge clk);
    end
  endtask

  // memory and side-port responders
  initial begin
    bit rsp_pend = 0, sp_pend = 0;
    int rsp_dly = 0, sp_dly = 0;
    logic [31:0] rsp_a = '0, sp_a = '0;
    bit r;
    forever begin
      @(negedge clk);
      rd_rsp_valid = 1'b0;
      side_rsp_valid = 1'b0;
      if (rsp_pend) begin
        if (rsp_dly == 0) begin
          rd_rsp_valid = 1'b1; rd_rsp_data = mem[rsp_a[9:2]]; rsp_pend = 0;
        end else rsp_dly--;
      end
      r = stall_en ? ($urandom % 4 != 0) : 1'b1;
      rd_req_ready = r;
      if (rd_req_valid && r) begin
        rsp_pend = 1; rsp_a = rd_req_addr; rsp_dly = stall_en ? int'($urandom % 3) : 0;
        rd_count++;
      end
      r = stall_en ? ($urandom % 3 != 0) : 1'b1;
      wr_ready = r;
      if (wr_valid && r) begin
        mem[wr_addr[9:2]] = wr_data; wr_count++;
      end
      if (sp_pend) begin
        if (sp_dly == 0) begin
          side_rsp_valid = 1'b1; side_rsp_data = side_val(sp_a); sp_pend = 0;
        end else sp_dly--;
      end
      r = stall_en ? ($urandom % 2 != 0) : 1'b1;
      side_req_ready = r;
      if (side_req_valid && r) begin
        sp_pend = 1; sp_a = side_req_addr; sp_dly = int'($urandom % 3);
        side_count++; last_side_addr = side_req_addr;
      end
    end
  end

  task automatic run_copy(input int src_w, input int dst_w, input int len, input bit swp,
                          input string tag);
    logic [31:0] d;
    int bad;
    logic [31:0] bad_act, bad_exp;
    bus_wr(5'h00, 1, 32'(src_w * 4));
    bus_wr(5'h04, 1, 32'(dst_w * 4));
    bus_wr(5'h0E, 0, swp ? 32'h80 : 32'h00);
    for (int i = 0; i < 256; i++) snap[i] = mem[i];
    wr_count = 0;
    bus_wr(5'h08, 1, 32'(len));
    wait_irq(4000);
    bad = 0; bad_act = '0; bad_exp = '0;
    for (int i = 0; i < 256; i++) begin
      logic [31:0] e;
      e = snap[i];
      if (i >= dst_w && i < dst_w + len) e = swp ? bswap(snap[src_w + i - dst_w]) : snap[src_w + i - dst_w];
      if (mem[i] !== e && bad == 0) begin bad = 1; bad_act = mem[i]; bad_exp = e; end
    end
    check({tag, " R3 R4 R12 copied data"}, bad_act, bad_exp);
    check({tag, " R3 write count"}, 32'(wr_count), 32'(len));
    bus_rd(5'h08, 1, d);
    check({tag, " R5 length cleared"}, d, 32'h0);
    bus_rd(5'h0C, 0, d);
    check({tag, " R5 status bit0"}, {31'h0, d[0]}, 32'h1);
    check({tag, " R5 irq high"}, {31'h0, irq}, 32'h1);
    bus_wr(5'h0D, 0, 32'h01);
    check({tag, " R6 irq cleared"}, {31'h0, irq}, 32'h0);
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 32; a += 4) begin
      bus_rd(5'(a), 1, d);
      check("R1 register reset", d, 32'h0);
    end
    check("R1 irq reset", {31'h0, irq}, 32'h0);
    check("R1 no requests", {29'h0, rd_req_valid, wr_valid, side_req_valid}, 32'h0);

    // R2 byte lanes
    bus_wr(5'h00, 1, 32'h1122_3344);
    bus_rd(5'h00, 0, d); check("R2 byte 0 is msb", d, 32'h11);
    bus_rd(5'h03, 0, d); check("R2 byte 3 is lsb", d, 32'h44);
    bus_rd(5'h02, 1, d); check("R2 word read ignores low bits", d, 32'h1122_3344);
    bus_wr(5'h05, 0, 32'hFFFF_FFAB);
    bus_rd(5'h04, 1, d); check("R2 byte write lane", d, 32'h00AB_0000);

    // R3 R4 directed
    run_copy(4, 130, 5, 0, "plain");
    run_copy(10, 140, 6, 1, "swap");
    run_copy(0, 200, 1, 1, "single");

    // R6 bit0 = 0 leaves status
    bus_wr(5'h08, 1, 32'h2);
    wait_irq(200);
    bus_wr(5'h0D, 0, 32'h02);
    check("R6 control without bit0", {31'h0, irq}, 32'h1);
    bus_wr(5'h0D, 0, 32'h01);
    check("R6 control with bit0", {31'h0, irq}, 32'h0);

    // R7 zero length
    wr_count = 0; rd_count = 0;
    bus_wr(5'h08, 1, 32'h0);
    @(negedge clk);
    check("R7 zero length done", {31'h0, irq}, 32'h1);
    check("R7 zero length no traffic", 32'(wr_count + rd_count), 32'h0);
    bus_wr(5'h0D, 0, 32'h01);

    // R8 blocked restart, with stalls
    stall_en = 1;
    bus_wr(5'h00, 1, 32'd64);
    bus_wr(5'h04, 1, 32'd800);
    bus_wr(5'h0E, 0, 32'h00);
    wr_count = 0;
    bus_wr(5'h08, 1, 32'd8);
    bus_wr(5'h08, 1, 32'd4);
    bus_rd(5'h08, 1, d);
    check("R8 length kept while busy", d, 32'd8);
    wait_irq(4000);
    repeat (10) @(negedge clk);
    check("R8 no extra words", 32'(wr_count), 32'd8);
    bus_wr(5'h0D, 0, 32'h01);

    // R12 random copies under back-pressure
    for (int t = 0; t < 8; t++) begin
      int ln;
      ln = (t == 0) ? 32 : 1 + int'($urandom % 16);
      run_copy(int'($urandom % 32), 128 + int'($urandom % 64), ln, bit'($urandom % 2), "random");
    end

    // R9 identification
    side_count = 0;
    bus_wr(5'h10, 1, 32'h2000_0000);
    bus_rd(5'h14, 1, d); check("R9 id word", d, 32'h1786_11DB);
    bus_wr(5'h14, 1, 32'h0);
    bus_wr(5'h10, 1, 32'hA000_0005);
    repeat (6) @(negedge clk);
    bus_rd(5'h14, 1, d); check("R9 id when both bits", d, 32'h1786_11DB);
    check("R9 no side request", 32'(side_count), 32'h0);

    // R10 side read
    for (int t = 0; t < 3; t++) begin
      logic [7:0] ix;
      ix = (t == 0) ? 8'hA5 : 8'($urandom);
      bus_wr(5'h10, 1, {8'h80, 8'($urandom), 8'($urandom) & 8'h0F, ix});
      repeat (12) @(negedge clk);
      check("R10 side address", last_side_addr, {24'h840000, ix});
      bus_rd(5'h14, 1, d);
      check("R10 side result", d, side_val({24'h840000, ix}));
    end

    // R11 no-op command, forced result
    bus_rd(5'h14, 1, d);
    bus_wr(5'h10, 1, 32'h0000_0033);
    repeat (4) @(negedge clk);
    begin
      logic [31:0] d2;
      bus_rd(5'h14, 1, d2);
      check("R11 result unchanged", d2, d);
    end
    bus_wr(5'h14, 1, 32'h1234_5678);
    bus_rd(5'h14, 1, d); check("R11 result forced", d, 32'hFFFF_FFFF);

    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule